// File: doc/BRIEF.md
# Edge-Triggered One-Shot Delay Timer

This block is one timer channel that produces a single delayed interrupt pulse per trigger. Software first arms the channel with a start strobe. The channel then sits idle until a trigger arrives. A trigger is either a qualifying transition on the external timer pin or a further start strobe while the channel is armed. On a trigger the channel copies its data register into a down counter. The counter then decrements on each tick of the chosen count enable. When a tick finds the counter at zero, the channel emits a one-clock interrupt and goes back to waiting.

The timer pin passes through a two-flop synchronizer, then an optional glitch filter, then an edge detector whose polarity is programmable. Two count enables come from an external prescaler, and a select input chooses between them. The data register can be written at any time. A count already under way keeps the value it loaded. A stop strobe disarms the channel.

Top module: `dly_oneshot_timer`

## Requirements
- R1: After reset, `irq` is 0 and the channel is disarmed.
- R2: A `start` pulse while disarmed only arms the channel. No counting takes place and no `irq` appears until a trigger.
- R3: A `start` pulse while armed is a trigger. It loads the data register, and `irq` goes high after exactly D+1 selected ticks. D=0 therefore fires on the first tick.
- R4: The counter changes only on ticks of the selected source: `tick_sel`=0 picks `tick_a` and `tick_sel`=1 picks `tick_b`.
- R5: `irq` lasts one clock. The channel then stays armed and raises no further `irq` until a new trigger.
- R6: `edge_mode` sets the qualifying pin transitions: 2'b00 is rising, 2'b01 is falling, and 2'b10 or 2'b11 is both. A transition in the other direction is ignored.
- R7: Pin transitions are ignored while the channel is disarmed. While it is armed, a qualifying transition is loaded 3 clocks after the pin changes when the filter is off.
- R8: A `stop` pulse disarms the channel and abandons any count. It also suppresses an `irq` that would occur in the same cycle. Pin edges are then ignored until the channel is re-armed.
- R9: A trigger that arrives during a count restarts the count from a fresh reload, and only one `irq` results.
- R10: A data-register write (`dreg_we`) does not change a count in progress. The new value is used from the next trigger onward.
- R11: With `filt_en`=1, a pin level is accepted only after 3 consecutive equal synchronized samples, and the load happens 6 clocks after the pin changes. Pulses shorter than 3 clocks are dropped. With the filter off, a 1-clock pulse is detected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_a | input | 1 | Prescaled count enable, source 0 |
| tick_b | input | 1 | Prescaled count enable, source 1 |
| tick_sel | input | 1 | Count enable select |
| tin | input | 1 | Asynchronous timer trigger pin |
| filt_en | input | 1 | Glitch filter enable |
| edge_mode | input | 2 | Qualifying edge polarity |
| start | input | 1 | Arm strobe; acts as a software trigger when already armed |
| stop | input | 1 | Disarm strobe |
| dreg_we | input | 1 | Data register write enable |
| dreg_wdata | input | W | Data register write value |
| irq | output | 1 | One-clock interrupt pulse |

## Verification
The assertions check the counter on every cycle against its control inputs. They cover the reload on each trigger, the single decrement per tick, the hold between ticks, the one-clock width of `irq` and its origin at a zero count, the dormancy of the disarmed and armed states, and the effect of stop. Other behaviours can only be shown by the bench's scenarios, because they depend on what happens at the pin. These are the pin-to-load latency through the synchronizer and filter, glitch rejection, edge polarity decoding, the use of a deferred data-register write, and whole trigger-to-interrupt delays under slow tick patterns.

// File: rtl/dly_pkg.sv
package dly_pkg;

    typedef enum logic [1:0] {
        CH_OFF   = 2'b00,
        CH_ARMED = 2'b01,
        CH_RUN   = 2'b10
    } ch_state_e;

    localparam logic [1:0] EDGE_RISE = 2'b00;
    localparam logic [1:0] EDGE_FALL = 2'b01;

    typedef struct packed {
        logic arm;
        logic fire;
        logic halt;
    } ch_cmd_t;

    function automatic logic edge_hit(input logic [1:0] mode,
                                      input logic cur, input logic prv);
        case (mode)
            EDGE_RISE: return cur & ~prv;
            EDGE_FALL: return ~cur & prv;
            default:   return cur ^ prv;
        endcase
    endfunction

endpackage

// File: rtl/dly_tick_sel.sv
module dly_tick_sel #(
    parameter int unsigned NSRC = 2,
    localparam int unsigned SW = (NSRC > 1) ? $clog2(NSRC) : 1
) (
    input  logic [NSRC-1:0] src,
    input  logic [SW-1:0]   sel,
    output logic            tick
);
    always_comb tick = src[sel];
endmodule

// File: rtl/dly_pin_cond.sv
module dly_pin_cond #(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned FILT_LEN    = 3
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       pin,
    input  logic       filt_en,
    input  logic [1:0] edge_mode,
    output logic       evt
);
    import dly_pkg::*;

    logic [SYNC_STAGES-1:0] sync_q;
    logic [FILT_LEN-1:0]    hist_q;
    logic                   lvl_q, prv_q;
    logic                   s_pin, steady, lvl_n;

    assign s_pin  = sync_q[SYNC_STAGES-1];
    assign steady = (&hist_q) | (~|hist_q);

    always_comb begin
        if (filt_en) lvl_n = steady ? hist_q[0] : lvl_q;
        else         lvl_n = s_pin;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '0;
            hist_q <= '0;
            lvl_q  <= 1'b0;
            prv_q  <= 1'b0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], pin};
            hist_q <= {hist_q[FILT_LEN-2:0], s_pin};
            lvl_q  <= lvl_n;
            prv_q  <= lvl_q;
        end
    end

    assign evt = edge_hit(edge_mode, lvl_q, prv_q);
endmodule

// File: rtl/dly_chan_ctrl.sv
module dly_chan_ctrl #(
    parameter int unsigned W = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  dly_pkg::ch_cmd_t   cmd,
    input  logic               evt,
    input  logic               tick,
    input  logic [W-1:0]       reload,
    output dly_pkg::ch_state_e st,
    output logic [W-1:0]       cnt,
    output logic               trig,
    output logic               irq
);
    import dly_pkg::*;

    logic enabled;
    assign enabled = (st != CH_OFF);
    assign trig    = enabled && (cmd.fire || evt) && !cmd.halt;

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= CH_OFF;
            cnt <= '0;
            irq <= 1'b0;
        end else begin
            irq <= 1'b0;
            if (cmd.halt) begin
                st <= CH_OFF;
            end else if (cmd.arm && !enabled) begin
                st <= CH_ARMED;
            end else if (trig) begin
                cnt <= reload;
                st  <= CH_RUN;
            end else if (st == CH_RUN && tick) begin
                if (cnt == '0) begin
                    irq <= 1'b1;
                    st  <= CH_ARMED;
                end else begin
                    cnt <= cnt - 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/dly_oneshot_timer.sv
module dly_oneshot_timer #(
    parameter int unsigned W           = 16,
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned FILT_LEN    = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick_a,
    input  logic         tick_b,
    input  logic         tick_sel,
    input  logic         tin,
    input  logic         filt_en,
    input  logic [1:0]   edge_mode,
    input  logic         start,
    input  logic         stop,
    input  logic         dreg_we,
    input  logic [W-1:0] dreg_wdata,
    output logic         irq
);
    import dly_pkg::*;

    logic         tick, evt, trig;
    logic [W-1:0] dreg, cnt;
    ch_state_e    st;
    ch_cmd_t      cmd;

    always_comb begin
        cmd.arm  = start;
        cmd.fire = start;
        cmd.halt = stop;
    end

    always_ff @(posedge clk) begin
        if (rst)          dreg <= '0;
        else if (dreg_we) dreg <= dreg_wdata;
    end

    dly_tick_sel #(.NSRC(2)) u_tsel (
        .src ({tick_b, tick_a}),
        .sel (tick_sel),
        .tick(tick)
    );

    dly_pin_cond #(.SYNC_STAGES(SYNC_STAGES), .FILT_LEN(FILT_LEN)) u_pin (
        .clk      (clk),
        .rst      (rst),
        .pin      (tin),
        .filt_en  (filt_en),
        .edge_mode(edge_mode),
        .evt      (evt)
    );

    dly_chan_ctrl #(.W(W)) u_ctrl (
        .clk   (clk),
        .rst   (rst),
        .cmd   (cmd),
        .evt   (evt),
        .tick  (tick),
        .reload(dreg),
        .st    (st),
        .cnt   (cnt),
        .trig  (trig),
        .irq   (irq)
    );
endmodule

// File: rtl/dly_oneshot_timer_chk.sv
module dly_oneshot_timer_chk #(
    parameter int unsigned W = 16
) (
    input logic               clk,
    input logic               rst,
    input logic               tick,
    input logic               start,
    input logic               stop,
    input logic               trig,
    input logic               irq,
    input dly_pkg::ch_state_e st,
    input logic [W-1:0]       cnt,
    input logic [W-1:0]       dreg
);
    import dly_pkg::*;

    assert_irq_pulse_R5: assert property (@(posedge clk) disable iff (rst)
        irq |=> !irq);

    assert_irq_origin_R5: assert property (@(posedge clk) disable iff (rst)
        irq |-> ($past(st) == CH_RUN && $past(cnt) == '0 && $past(tick) && st == CH_ARMED));

    assert_load_R3: assert property (@(posedge clk) disable iff (rst)
        trig |=> (cnt == $past(dreg) && st == CH_RUN));

    assert_dec_R4: assert property (@(posedge clk) disable iff (rst)
        (st == CH_RUN && !trig && !stop && tick && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));

    assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (st == CH_RUN && !trig && !stop && !tick) |=> ($stable(cnt) && st == CH_RUN));

    assert_stop_R8: assert property (@(posedge clk) disable iff (rst)
        stop |=> (st == CH_OFF && !irq));

    assert_off_R7: assert property (@(posedge clk) disable iff (rst)
        (st == CH_OFF && !start) |=> (st == CH_OFF && !irq));

    assert_armed_R2: assert property (@(posedge clk) disable iff (rst)
        (st == CH_ARMED && !trig && !stop) |=> (st == CH_ARMED && $stable(cnt) && !irq));

endmodule

bind dly_oneshot_timer dly_oneshot_timer_chk #(.W(W)) u_chk (
    .clk  (clk),
    .rst  (rst),
    .tick (tick),
    .start(start),
    .stop (stop),
    .trig (trig),
    .irq  (irq),
    .st   (st),
    .cnt  (cnt),
    .dreg (dreg)
);

// File: tb/dly_oneshot_timer_tb.sv
`timescale 1ns/1ps
module dly_oneshot_timer_tb;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         tick_a = 1'b1, tick_b = 1'b1, tick_sel = 1'b0;
    logic         tin = 1'b0, filt_en = 1'b0;
    logic [1:0]   edge_mode = 2'b00;
    logic         start = 1'b0, stop = 1'b0, dreg_we = 1'b0;
    logic [W-1:0] dreg_wdata = '0;
    logic         irq;

    int total = 0, bad = 0;
    bit done = 0;
    int g_restart_at = 0, g_stop_at = 0, g_wr_at = 0, g_tin_drop = 0;
    logic [W-1:0] g_wr_val = '0;
    int first, nirq;

    always #2 clk = ~clk;

    dly_oneshot_timer #(.W(W)) u_dut (
        .clk(clk), .rst(rst), .tick_a(tick_a), .tick_b(tick_b), .tick_sel(tick_sel),
        .tin(tin), .filt_en(filt_en), .edge_mode(edge_mode), .start(start), .stop(stop),
        .dreg_we(dreg_we), .dreg_wdata(dreg_wdata), .irq(irq)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic write_dreg(input logic [W-1:0] v);
        dreg_we = 1'b1; dreg_wdata = v;
        @(posedge clk); #1;
        dreg_we = 1'b0;
    endtask

    // Step i = number of rising edges since the stimulus was applied.
    task automatic watch(input int n, input int per, input logic sel,
                         output int f, output int c);
        f = 0; c = 0;
        tick_sel = sel;
        if (sel) begin tick_b = (per == 1); tick_a = 1'b1; end
        else     begin tick_a = (per == 1); tick_b = 1'b1; end
        for (int i = 1; i <= n; i++) begin
            @(posedge clk); #1;
            start = 1'b0; stop = 1'b0; dreg_we = 1'b0;
            if (irq) begin if (f == 0) f = i; c++; end
            if (i == g_tin_drop)   tin = 1'b0;
            if (i == g_restart_at) start = 1'b1;
            if (i == g_stop_at)    stop = 1'b1;
            if (i == g_wr_at) begin dreg_we = 1'b1; dreg_wdata = g_wr_val; end
            if (sel) tick_b = ((i % per) == 0);
            else     tick_a = ((i % per) == 0);
        end
        g_restart_at = 0; g_stop_at = 0; g_wr_at = 0; g_tin_drop = 0;
        tick_a = 1'b1; tick_b = 1'b1; tick_sel = 1'b0;
    endtask

    task automatic t_reset_and_off();
        check(irq == 1'b0, "R1 irq after reset", irq, 0);
        edge_mode = 2'b10; tin = 1'b1;
        watch(20, 1, 1'b0, first, nirq);
        check(nirq == 0, "R7 edge while disarmed", nirq, 0);
        tin = 1'b0;
        watch(20, 1, 1'b0, first, nirq);
        check(nirq == 0, "R1 still disarmed", nirq, 0);
    endtask

    task automatic t_arm_and_sw();
        write_dreg(16'd5);
        start = 1'b1;
        watch(40, 1, 1'b0, first, nirq);
        check(nirq == 0, "R2 arm only", nirq, 0);
        start = 1'b1;
        watch(40, 1, 1'b0, first, nirq);
        check(first == 7, "R3 sw trigger delay D=5", first, 7);
        check(nirq == 1, "R5 single pulse then idle", nirq, 1);
        write_dreg(16'd0);
        start = 1'b1;
        watch(10, 1, 1'b0, first, nirq);
        check(first == 2, "R3 D=0 fires on first tick", first, 2);
        check(nirq == 1, "R5 D=0 single pulse", nirq, 1);
    endtask

    task automatic t_tick_sel();
        write_dreg(16'd2);
        start = 1'b1;
        watch(30, 3, 1'b1, first, nirq);
        check(first == 10, "R4 tick_b every 3rd clock", first, 10);
        write_dreg(16'd3);
        start = 1'b1;
        watch(30, 2, 1'b0, first, nirq);
        check(first == 9, "R4 tick_a every 2nd clock", first, 9);
    endtask

    task automatic t_edges();
        write_dreg(16'd4);
        edge_mode = 2'b00; tin = 1'b1;
        watch(30, 1, 1'b0, first, nirq);
        check(first == 9, "R7 rising edge load latency", first, 9);
        edge_mode = 2'b01; tin = 1'b0;
        watch(30, 1, 1'b0, first, nirq);
        check(first == 9, "R6 falling mode", first, 9);
        tin = 1'b1;
        watch(30, 1, 1'b0, first, nirq);
        check(nirq == 0, "R6 rising ignored in falling mode", nirq, 0);
        edge_mode = 2'b10; tin = 1'b0;
        watch(30, 1, 1'b0, first, nirq);
        check(first == 9, "R6 both mode falling", first, 9);
        edge_mode = 2'b11; tin = 1'b1;
        watch(30, 1, 1'b0, first, nirq);
        check(first == 9, "R6 mode 11 rising", first, 9);
        edge_mode = 2'b00; tin = 1'b0;
        watch(30, 1, 1'b0, first, nirq);
        check(nirq == 0, "R6 falling ignored in rising mode", nirq, 0);
    endtask

    task automatic t_filter();
        write_dreg(16'd4);
        edge_mode = 2'b00;
        tin = 1'b1; g_tin_drop = 1;
        watch(30, 1, 1'b0, first, nirq);
        check(first == 9, "R11 unfiltered 1-clock pulse", first, 9);
        filt_en = 1'b1;
        watch(10, 1, 1'b0, first, nirq);
        tin = 1'b1; g_tin_drop = 2;
        watch(30, 1, 1'b0, first, nirq);
        check(nirq == 0, "R11 2-clock glitch rejected", nirq, 0);
        tin = 1'b1; g_tin_drop = 3;
        watch(30, 1, 1'b0, first, nirq);
        check(first == 12, "R11 3-clock pulse filtered latency", first, 12);
        filt_en = 1'b0;
        watch(10, 1, 1'b0, first, nirq);
    endtask

    task automatic t_retrigger();
        write_dreg(16'd10);
        start = 1'b1; g_restart_at = 5;
        watch(40, 1, 1'b0, first, nirq);
        check(first == 17, "R9 restart from fresh reload", first, 17);
        check(nirq == 1, "R9 single irq", nirq, 1);
    endtask

    task automatic t_dreg_defer();
        write_dreg(16'd10);
        start = 1'b1; g_wr_at = 3; g_wr_val = 16'd2;
        watch(30, 1, 1'b0, first, nirq);
        check(first == 12, "R10 write during count ignored", first, 12);
        start = 1'b1;
        watch(20, 1, 1'b0, first, nirq);
        check(first == 4, "R10 new value on next trigger", first, 4);
    endtask

    task automatic t_stop();
        write_dreg(16'd10);
        start = 1'b1; g_stop_at = 4;
        watch(30, 1, 1'b0, first, nirq);
        check(nirq == 0, "R8 stop abandons count", nirq, 0);
        edge_mode = 2'b10; tin = 1'b1;
        watch(20, 1, 1'b0, first, nirq);
        check(nirq == 0, "R8 edge ignored after stop", nirq, 0);
        start = 1'b1;
        watch(20, 1, 1'b0, first, nirq);
        check(nirq == 0, "R2 re-arm after stop", nirq, 0);
        start = 1'b1;
        watch(20, 1, 1'b0, first, nirq);
        check(first == 12, "R8 channel usable after re-arm", first, 12);
        write_dreg(16'd3);
        start = 1'b1; g_stop_at = 4;
        watch(20, 1, 1'b0, first, nirq);
        check(nirq == 0, "R8 stop suppresses same-cycle irq", nirq, 0);
        tin = 1'b0;
        watch(10, 1, 1'b0, first, nirq);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
        @(posedge clk); #1;
        t_reset_and_off();
        t_arm_and_sw();
        t_tick_sel();
        t_edges();
        t_filter();
        t_retrigger();
        t_dreg_defer();
        t_stop();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #(4 * 100000);
        if (!done) begin
            done = 1;
            total++; bad++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule